// File: doc/BRIEF.md
# Configurable Interrupt Status Controller

This block gathers up to eight synchronous interrupt sources into a single interrupt request. Each source has its own 2-bit trigger code, which selects between a rising edge, a falling edge and a level condition. Every qualifying event is held in a sticky status register until software reads it. A mask register decides which sources may record events and drive the request. A separate 2-bit field sets the electrical form of the output: active high, active low, or open-drain active low.

Software reaches the registers through a simple single-cycle port. A read of the status register returns the held bits and clears them on the same clock edge. Two exceptions apply. A level-mode source that is still true stays set. An event that arrives in the cycle of the read is also kept, so that no event is lost.

Register map:

| Address | Register | Contents |
|---|---|---|
| 0 | status | read-only |
| 1 | mask | per-source enable |
| 2 | mode high | upper bit of each trigger code |
| 3 | mode low | lower bit of each trigger code |
| 4 | output config | polarity in bits [1:0] |

Any other address reads 0.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the status, mask, mode-high, mode-low and output-config registers all read 00h. The output is inactive, with `irq_o`=0 and `irq_oe_o`=1.
- R2: In trigger code 00 (rising), a status bit sets on the clock edge at which its source is 1 and was 0 on the previous edge. A source that stays high sets nothing new, and a 1-to-0 change sets nothing.
- R3: In trigger code 01 (falling), a status bit sets on the edge at which its source is 0 and was 1 on the previous edge. A 0-to-1 change sets nothing.
- R4: In trigger code 10 (level), a status bit sets on every edge while its source is 1. A status read leaves that bit at 1 while the source is still 1.
- R5: Trigger code 11 is reserved, and its source never sets its status bit.
- R6: A status bit stays at 1 after its source goes away, until a status read or until its mask bit is cleared.
- R7: A read of address 0 returns the status as it was before the read, and then clears every bit that R4 and R10 do not keep.
- R8: A mask bit of 1 enables source i at bit i. With mask bit 0, status bit i reads 0 and has no effect on the output, including when the bit was set before the mask was cleared.
- R9: The trigger code of source i is {mode-high bit i, mode-low bit i}.
- R10: An enabled event on the same clock edge as a status read is kept set after the read.
- R11: The output is active exactly while at least one readable status bit is 1.
- R12: Output config bits [1:0] select the output form. 00 drives `irq_o` equal to active, with `irq_oe_o`=1. 01 drives `irq_o` equal to not active, with `irq_oe_o`=1. 10 holds `irq_o` at 0 and sets `irq_oe_o` equal to active. 11 behaves like 00.
- R13: Mask, mode and output-config registers read back what was written, with output-config bits [7:2] reading 0. A write to address 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 8 | Interrupt sources, synchronous to clk |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; clears status when addressing 0 |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Interrupt output level |
| irq_oe_o | output | 1 | Output enable for the interrupt pin |

## Verification
A source change applied between edges shows up in status, and therefore in `irq_o`, after exactly one rising clock edge. Read data is combinational, so the value returned by a status read is the pre-clear value, sampled before the edge that performs the clear. Register writes take effect on the next edge, and the output form follows combinationally from then on. The bench drives every input just after a falling edge and samples 1 ns later, so each result is checked one edge after its cause and never at an edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_LEVEL = 2'b10,
    TRIG_RSVD  = 2'b11
  } trig_e;

  typedef enum logic [1:0] {
    POL_HIGH  = 2'b00,
    POL_LOW   = 2'b01,
    POL_ODRN  = 2'b10,
    POL_RSVD  = 2'b11
  } pol_e;

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd1;
  localparam logic [ADDR_W-1:0] A_MODEH  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MODEL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CFG    = 3'd4;
endpackage

// File: rtl/irq_trigger.sv
module irq_trigger #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] mode_hi_i,
  input  logic [N_SRC-1:0] mode_lo_i,
  output logic [N_SRC-1:0] evt_o
);
  import irq_pkg::*;

  logic [N_SRC-1:0] src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_i;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    trig_e code;
    assign code = trig_e'({mode_hi_i[i], mode_lo_i[i]});
    always_comb begin
      unique case (code)
        TRIG_RISE:  evt_o[i] = src_i[i] & ~src_q[i];
        TRIG_FALL:  evt_o[i] = ~src_i[i] & src_q[i];
        TRIG_LEVEL: evt_o[i] = src_i[i];
        default:    evt_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic             rd_clr_i,
  output logic [N_SRC-1:0] stat_o
);
  logic [N_SRC-1:0] stat_q, stat_d;

  always_comb begin
    if (rd_clr_i) stat_d = evt_i;
    else          stat_d = stat_q | evt_i;
    stat_d = stat_d & mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  // R7: after a read, nothing survives except what an event re-set
  a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_clr_i) |-> ((stat_q & ~$past(evt_i)) == '0));

  // R6: without a read, a set and still-enabled bit stays set
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_clr_i) |-> (($past(stat_q) & $past(mask_i) & ~stat_q) == '0));

  // R8: a bit disabled on the previous edge holds 0
  a_r8_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(mask_i)) == '0));

  // R10: an enabled event is always recorded, read or not
  a_r10_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_i & mask_i) & ~stat_q) == '0));
endmodule

// File: rtl/irq_pin.sv
module irq_pin (
  input  logic       active_i,
  input  logic [1:0] pol_i,
  output logic       irq_o,
  output logic       irq_oe_o
);
  import irq_pkg::*;

  always_comb begin
    unique case (pol_e'(pol_i))
      POL_LOW: begin
        irq_o    = ~active_i;
        irq_oe_o = 1'b1;
      end
      POL_ODRN: begin
        irq_o    = 1'b0;
        irq_oe_o = active_i;
      end
      default: begin
        irq_o    = active_i;
        irq_oe_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_SRC-1:0]           src_i,
  input  logic                       reg_wr_i,
  input  logic                       reg_rd_i,
  input  logic [irq_pkg::ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]              reg_wdata_i,
  output logic [DW-1:0]              reg_rdata_o,
  output logic                       irq_o,
  output logic                       irq_oe_o
);
  import irq_pkg::*;

  localparam int unsigned POL_W = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [N_SRC-1:0] mask_q, mask_d, modeh_q, modeh_d, model_q, model_d;
  logic [POL_W-1:0] pol_q, pol_d;
  logic [N_SRC-1:0] evt, stat;
  logic             rd_clr, active;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  always_comb begin
    mask_d  = mask_q;
    modeh_d = modeh_q;
    model_d = model_q;
    pol_d   = pol_q;
    if (reg_wr_i) begin
      unique case (reg_addr_i)
        A_MASK:  mask_d  = reg_wdata_i[N_SRC-1:0];
        A_MODEH: modeh_d = reg_wdata_i[N_SRC-1:0];
        A_MODEL: model_d = reg_wdata_i[N_SRC-1:0];
        A_CFG:   pol_d   = reg_wdata_i[POL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      mask_q  <= '0;
      modeh_q <= '0;
      model_q <= '0;
      pol_q   <= '0;
    end else if (reg_wr_i) begin
      mask_q  <= mask_d;
      modeh_q <= modeh_d;
      model_q <= model_d;
      pol_q   <= pol_d;
    end
  end

  assign rd_clr = reg_rd_i && (reg_addr_i == A_STATUS);

  irq_trigger #(.N_SRC(N_SRC)) u_trig (
    .clk(clk), .rst_n(rst_core_n), .src_i(src_i),
    .mode_hi_i(modeh_q), .mode_lo_i(model_q), .evt_o(evt)
  );

  irq_sticky #(.N_SRC(N_SRC)) u_stat (
    .clk(clk), .rst_n(rst_core_n), .evt_i(evt), .mask_i(mask_q),
    .rd_clr_i(rd_clr), .stat_o(stat)
  );

  logic [N_SRC-1:0] stat_vis;
  assign stat_vis = stat & mask_q;
  assign active   = |stat_vis;

  irq_pin u_pin (
    .active_i(active), .pol_i(pol_q), .irq_o(irq_o), .irq_oe_o(irq_oe_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_STATUS: reg_rdata_o[N_SRC-1:0] = stat_vis;
      A_MASK:   reg_rdata_o[N_SRC-1:0] = mask_q;
      A_MODEH:  reg_rdata_o[N_SRC-1:0] = modeh_q;
      A_MODEL:  reg_rdata_o[N_SRC-1:0] = model_q;
      A_CFG:    reg_rdata_o[POL_W-1:0] = pol_q;
      default:  ;
    endcase
  end

  // R11: with active-high form the pin mirrors the readable status
  a_r11_irq_tracks: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pol_q == 2'b00) |-> (irq_o == |stat_vis));

  // R12: open-drain form never drives high
  a_r12_odrain_low: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pol_q == 2'b10) |-> (!irq_o && (irq_oe_o == |stat_vis)));
endmodule

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, irq_oe;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  irq_status_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .irq_oe_o(irq_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic rd_stat(output logic [7:0] v);
    @(negedge clk); reg_addr = 3'd0; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic drive(input logic [7:0] v);
    @(negedge clk); src = v;
  endtask

  task automatic pin(input string req, input logic eo, input logic eoe);
    #1 chk(req, {6'd0, irq, irq_oe}, {6'd0, eo, eoe});
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 5; a++) begin
      peek(3'(a), v); chk("R1 register reset", v, 8'h00);
    end
    pin("R1 output inactive", 1'b0, 1'b1);
  endtask

  task automatic t_setup();
    logic [7:0] v;
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'h0C);   // bit2 level (10), bit3 reserved (11)
    wr(3'd3, 8'h0A);   // bit1 falling (01)
    wr(3'd4, 8'hFC);   // polarity 00, upper bits dropped
    wr(3'd0, 8'hFF);   // status not writable
    peek(3'd1, v); chk("R13 mask readback", v, 8'hFF);
    peek(3'd2, v); chk("R13 mode-high readback", v, 8'h0C);
    peek(3'd3, v); chk("R13 mode-low readback", v, 8'h0A);
    peek(3'd4, v); chk("R13 config readback", v, 8'h00);
    peek(3'd0, v); chk("R13 status write ignored", v, 8'h00);
  endtask

  task automatic t_rise();
    logic [7:0] v;
    drive(8'h01);
    peek(3'd0, v); chk("R2 rising sets", v, 8'h01);
    pin("R11 irq active", 1'b1, 1'b1);
    rd_stat(v); chk("R7 read returns pre-clear", v, 8'h01);
    peek(3'd0, v); chk("R2 steady high sets nothing", v, 8'h00);
    pin("R11 irq idle", 1'b0, 1'b1);
    drive(8'h00);
    peek(3'd0, v); chk("R2 falling change ignored", v, 8'h00);
  endtask

  task automatic t_fall();
    logic [7:0] v;
    drive(8'h02);
    peek(3'd0, v); chk("R3 rise ignored in falling mode", v, 8'h00);
    drive(8'h00);
    peek(3'd0, v); chk("R3 R9 falling sets", v, 8'h02);
    rd_stat(v);
    peek(3'd0, v); chk("R7 cleared", v, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] v;
    drive(8'h04);
    peek(3'd0, v); chk("R4 level sets", v, 8'h04);
    rd_stat(v); chk("R4 read value", v, 8'h04);
    peek(3'd0, v); chk("R4 kept while true", v, 8'h04);
    drive(8'h00);
    repeat (3) @(negedge clk);
    peek(3'd0, v); chk("R6 sticky after removal", v, 8'h04);
    rd_stat(v);
    peek(3'd0, v); chk("R7 level cleared once false", v, 8'h00);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    drive(8'h08);
    peek(3'd0, v); chk("R5 reserved rise", v, 8'h00);
    drive(8'h00);
    peek(3'd0, v); chk("R5 reserved fall", v, 8'h00);
    pin("R5 no output", 1'b0, 1'b1);
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    drive(8'h10);
    drive(8'h00);
    repeat (5) @(negedge clk);
    peek(3'd0, v); chk("R6 pulse held", v, 8'h10);
    rd_stat(v); chk("R6 read value", v, 8'h10);
    peek(3'd0, v); chk("R7 cleared after pulse", v, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    wr(3'd1, 8'hDF);
    drive(8'h20);
    peek(3'd0, v); chk("R8 masked source", v, 8'h00);
    pin("R8 masked no output", 1'b0, 1'b1);
    drive(8'h60);
    peek(3'd0, v); chk("R8 unmasked source", v, 8'h40);
    wr(3'd1, 8'h9F);
    peek(3'd0, v); chk("R8 hidden once masked", v, 8'h00);
    pin("R8 hidden bit no output", 1'b0, 1'b1);
    drive(8'h00);
    wr(3'd1, 8'hFF);
    rd_stat(v);
  endtask

  task automatic t_coincide();
    logic [7:0] v;
    @(negedge clk); reg_addr = 3'd0; reg_rd = 1'b1; src = 8'h80; #1 v = reg_rdata;
    chk("R10 pre-read value", v, 8'h00);
    @(negedge clk); reg_rd = 1'b0;
    peek(3'd0, v); chk("R10 event kept across read", v, 8'h80);
  endtask

  task automatic t_polarity();
    logic [7:0] v;
    wr(3'd4, 8'h01);
    pin("R12 active-low asserted", 1'b0, 1'b1);
    wr(3'd4, 8'h03);
    pin("R12 reserved acts high", 1'b1, 1'b1);
    wr(3'd4, 8'h02);
    pin("R12 open-drain asserted", 1'b0, 1'b1);
    rd_stat(v);
    pin("R12 open-drain released", 1'b0, 1'b0);
    wr(3'd4, 8'h01);
    pin("R12 active-low idle", 1'b1, 1'b1);
    wr(3'd4, 8'h00);
    pin("R12 active-high idle", 1'b0, 1'b1);
    drive(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_setup();
    t_rise();
    t_fall();
    t_level();
    t_reserved();
    t_sticky();
    t_mask();
    t_coincide();
    t_polarity();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule